// File: doc/BRIEF.md
# Page Video Streamer

This block sends one rendered page, or one band of a page, from memory to a laser print engine as a serial bit stream. Software writes the image start address, the number of 16-bit words in each scanline and the number of scanlines. The write that sets the scanline count arms the block. From then on the block needs no further software action until the page is finished.

Once armed, the block fetches image words over a request/acknowledge read port into a two-word buffer. When the buffer is full, it raises a print request and waits for the engine's frame sync. The rising edge of frame sync drops the request and raises a band-begin interrupt. After that, each rising edge of line sync starts one scanline.

Each scanline is shifted out one bit per rising edge of the engine's video clock, most significant bit of each word first. Once the last scanline has been sent, the block raises a page-end interrupt and returns to idle. Both interrupts and an underrun flag are sticky, and software clears them by writing ones.

All engine inputs are already synchronous to `clk_i`. The block detects their rising edges by comparing each one with its value in the previous cycle.

Top module: `page_video_ctrl`

## Requirements
- R1: While `rst_ni` is low, `mem_req_o`, `print_req_o`, `video_o`, `irq_band_o`, `irq_page_o` and `underrun_o` are all 0.
- R2: Register writes use `cfg_we_i`, `cfg_addr_i` and `cfg_wdata_i`. Address 0 holds the start word address, address 1 the words per line and address 2 the line count. Writes to these three addresses take effect only while the block is idle. The block arms only on a write to address 2, and only if the block is idle, the written count is nonzero and the stored words per line is nonzero. In the cycle after the arming write, `mem_req_o` is 1 and `mem_addr_o` equals the start address.
- R3: Fetches read consecutive word addresses. The block keeps at most two words fetched but not yet sent. Once `mem_req_o` is raised, it stays high with `mem_addr_o` unchanged until `mem_ack_i` is seen. Fetching stops after words-per-line × lines words, and the block never requests while idle.
- R4: `print_req_o` rises in the cycle after the buffer becomes full, or after every word of the image has been fetched. It stays high until the first rising edge of `fsync_i` after that point. That edge drops `print_req_o` and sets `irq_band_o` in the same cycle.
- R5: A scanline starts on the first rising edge of `vclk_i` that is sampled in a cycle after the one in which a rising edge of `lsync_i` was sampled. `video_o` carries the first bit one cycle after that `vclk_i` edge is sampled.
- R6: Each scanline sends exactly words-per-line × 16 bits, one bit per rising edge of `vclk_i`, with bit 15 of each word first. On the following rising edge of `vclk_i`, `video_o` returns to 0, and it stays 0 until the next scanline starts.
- R7: Rising edges of `lsync_i` that arrive while a scanline is being sent, or before the frame sync edge, start nothing.
- R8: `irq_page_o` is set at the edge of `vclk_i` that ends the last scanline. The block then returns to idle and can be armed again.
- R9: If a word is needed while the buffer is empty, 16 zero bits are sent in its place and `underrun_o` is set.
- R10: A write to address 3 clears the sticky flags whose data bits are 1 (bit 0 band-begin, bit 1 page-end, bit 2 underrun). Zero bits leave their flags unchanged. If a flag is set and cleared in the same cycle, setting wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 2 | Register address |
| cfg_wdata_i | input | AW (20) | Register write data |
| mem_req_o | output | 1 | Word read request |
| mem_addr_o | output | AW (20) | Word address of the read |
| mem_ack_i | input | 1 | Read acknowledge; data is valid in the same cycle |
| mem_rdata_i | input | 16 | Read data |
| print_req_o | output | 1 | Asks the engine to print a page |
| fsync_i | input | 1 | Top-of-page sync from the engine |
| lsync_i | input | 1 | Scanline sync from the engine |
| vclk_i | input | 1 | Video clock from the engine, already synchronised |
| video_o | output | 1 | Serial video data |
| irq_band_o | output | 1 | Sticky band-begin interrupt |
| irq_page_o | output | 1 | Sticky page-end interrupt |
| underrun_o | output | 1 | Sticky buffer underrun flag |

## Verification
A wrong bit counter or a wrong word counter shows on `video_o` at the very next video clock edge: a line comes out too long or too short, or a word comes out in the wrong bit order. A wrong buffer count shows first on `mem_req_o`, in the same cycle, as a request that is missing or one that should not be there. A wrong line counter shows only when the page ends, as `irq_page_o` rising early or not at all. For that reason the bench predicts every output in every cycle, rather than checking only the final flags.

// File: rtl/pvc_pkg.sv
package pvc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_WAIT = 2'd2,
    ST_RUN  = 2'd3
  } pvc_state_e;

  localparam logic [1:0] REG_BASE  = 2'd0;
  localparam logic [1:0] REG_WPL   = 2'd1;
  localparam logic [1:0] REG_LINES = 2'd2;
  localparam logic [1:0] REG_STAT  = 2'd3;

  localparam int unsigned FLAG_BAND = 0;
  localparam int unsigned FLAG_PAGE = 1;
  localparam int unsigned FLAG_URUN = 2;
endpackage

// File: rtl/pvc_regs.sv
module pvc_regs
  import pvc_pkg::*;
#(
  parameter int unsigned AW    = 20,
  parameter int unsigned WPL_W = 10,
  parameter int unsigned LN_W  = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [1:0]       cfg_addr_i,
  input  logic [AW-1:0]    cfg_wdata_i,
  input  logic             idle_i,
  input  logic             set_band_i,
  input  logic             set_page_i,
  input  logic             set_urun_i,
  output logic [AW-1:0]    base_o,
  output logic [WPL_W-1:0] wpl_o,
  output logic [LN_W-1:0]  lines_o,
  output logic             arm_o,
  output logic             irq_band_o,
  output logic             irq_page_o,
  output logic             urun_o
);
  logic [2:0] clr;
  logic       geo_we;

  assign geo_we = cfg_we_i && idle_i;
  assign clr    = (cfg_we_i && cfg_addr_i == REG_STAT) ? cfg_wdata_i[2:0] : 3'b000;
  assign arm_o  = geo_we && cfg_addr_i == REG_LINES
                  && cfg_wdata_i[LN_W-1:0] != '0 && wpl_o != '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_o  <= '0;
      wpl_o   <= '0;
      lines_o <= '0;
    end else if (geo_we) begin
      case (cfg_addr_i)
        REG_BASE:  base_o  <= cfg_wdata_i;
        REG_WPL:   wpl_o   <= cfg_wdata_i[WPL_W-1:0];
        REG_LINES: lines_o <= cfg_wdata_i[LN_W-1:0];
        default: ;
      endcase
    end
  end

  // set beats clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_band_o <= 1'b0;
      irq_page_o <= 1'b0;
      urun_o     <= 1'b0;
    end else begin
      irq_band_o <= (irq_band_o & ~clr[FLAG_BAND]) | set_band_i;
      irq_page_o <= (irq_page_o & ~clr[FLAG_PAGE]) | set_page_i;
      urun_o     <= (urun_o     & ~clr[FLAG_URUN]) | set_urun_i;
    end
  end
endmodule

// File: rtl/pvc_fetch.sv
module pvc_fetch #(
  parameter int unsigned AW    = 20,
  parameter int unsigned DW    = 16,
  parameter int unsigned DEPTH = 2,
  parameter int unsigned TW    = 24
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          active_i,
  input  logic          start_i,
  input  logic [AW-1:0] base_i,
  input  logic [TW-1:0] total_i,
  input  logic          pop_i,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic          mem_ack_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [DW-1:0] head_o,
  output logic          empty_o,
  output logic          full_o,
  output logic          done_o
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [DW-1:0] slot_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic [TW-1:0] left_q;
  logic [AW-1:0] addr_q;
  logic          push;

  function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign mem_req_o  = active_i && left_q != '0 && cnt_q < CW'(DEPTH);
  assign mem_addr_o = addr_q;
  assign push       = mem_req_o && mem_ack_i;
  assign empty_o    = cnt_q == '0;
  assign full_o     = cnt_q == CW'(DEPTH);
  assign done_o     = left_q == '0;
  assign head_o     = slot_q[rd_q];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk_i) begin
      if (push && wr_q == PW'(i)) slot_q[i] <= mem_rdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q   <= '0;
      rd_q   <= '0;
      cnt_q  <= '0;
      left_q <= '0;
      addr_q <= '0;
    end else if (start_i) begin
      wr_q   <= '0;
      rd_q   <= '0;
      cnt_q  <= '0;
      left_q <= total_i;
      addr_q <= base_i;
    end else begin
      if (push) begin
        wr_q   <= wrap_inc(wr_q);
        left_q <= left_q - 1'b1;
        addr_q <= addr_q + 1'b1;
      end
      if (pop_i) rd_q <= wrap_inc(rd_q);
      case ({push, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: ;
      endcase
    end
  end

  // R3
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i && !start_i) |=> (mem_req_o && $stable(mem_addr_o)));
  // R3
  fifo_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  // R9
  pop_nonempty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/pvc_shift.sv
module pvc_shift #(
  parameter int unsigned DW    = 16,
  parameter int unsigned WPL_W = 10,
  parameter int unsigned LN_W  = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             start_i,
  input  logic [WPL_W-1:0] wpl_i,
  input  logic [LN_W-1:0]  lines_i,
  input  logic             vclk_i,
  input  logic             lsync_i,
  input  logic [DW-1:0]    head_i,
  input  logic             empty_i,
  output logic             pop_o,
  output logic             urun_o,
  output logic             page_done_o,
  output logic             video_o
);
  localparam int unsigned BW = $clog2(DW);

  logic             vclk_q, lsync_q, pend_q, in_line_q;
  logic [DW-1:0]    sh_q;
  logic [BW-1:0]    bits_q;
  logic [WPL_W-1:0] words_q;
  logic [LN_W-1:0]  lines_left_q;
  logic             vrise, lrise, word_end, load, advance, end_line;
  logic [DW-1:0]    word;

  assign vrise    = vclk_i && !vclk_q;
  assign lrise    = lsync_i && !lsync_q;
  assign word_end = bits_q == '0;
  assign load     = run_i && vrise && ((!in_line_q && pend_q) ||
                    (in_line_q && word_end && words_q != '0));
  assign advance  = run_i && vrise && in_line_q && !word_end;
  assign end_line = run_i && vrise && in_line_q && word_end && words_q == '0;
  assign pop_o    = load && !empty_i;
  assign urun_o   = load && empty_i;
  assign word     = empty_i ? '0 : head_i;
  assign page_done_o = end_line && lines_left_q == LN_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vclk_q  <= 1'b0;
      lsync_q <= 1'b0;
    end else begin
      vclk_q  <= vclk_i;
      lsync_q <= lsync_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q       <= 1'b0;
      in_line_q    <= 1'b0;
      sh_q         <= '0;
      bits_q       <= '0;
      words_q      <= '0;
      lines_left_q <= '0;
      video_o      <= 1'b0;
    end else if (start_i) begin
      pend_q       <= 1'b0;
      in_line_q    <= 1'b0;
      lines_left_q <= lines_i;
      video_o      <= 1'b0;
    end else begin
      // line sync only counts between lines
      if (run_i && lrise && !in_line_q) pend_q <= 1'b1;
      if (load) begin
        video_o   <= word[DW-1];
        sh_q      <= word << 1;
        bits_q    <= BW'(DW - 1);
        words_q   <= in_line_q ? words_q - 1'b1 : wpl_i - 1'b1;
        in_line_q <= 1'b1;
        pend_q    <= 1'b0;
      end else if (advance) begin
        video_o <= sh_q[DW-1];
        sh_q    <= sh_q << 1;
        bits_q  <= bits_q - 1'b1;
      end else if (end_line) begin
        video_o      <= 1'b0;
        in_line_q    <= 1'b0;
        lines_left_q <= lines_left_q - 1'b1;
      end
    end
  end

  // R5
  line_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(in_line_q) |-> $rose(vclk_q));
  // R6
  idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(in_line_q) |-> !video_o);
  // R8
  last_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    page_done_o |=> lines_left_q == '0);
endmodule

// File: rtl/page_video_ctrl.sv
module page_video_ctrl
  import pvc_pkg::*;
#(
  parameter int unsigned AW    = 20,
  parameter int unsigned DW    = 16,
  parameter int unsigned WPL_W = 10,
  parameter int unsigned LN_W  = 14,
  parameter int unsigned DEPTH = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic [1:0]    cfg_addr_i,
  input  logic [AW-1:0] cfg_wdata_i,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic          mem_ack_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          print_req_o,
  input  logic          fsync_i,
  input  logic          lsync_i,
  input  logic          vclk_i,
  output logic          video_o,
  output logic          irq_band_o,
  output logic          irq_page_o,
  output logic          underrun_o
);
  localparam int unsigned TW = WPL_W + LN_W;

  pvc_state_e       state_q, state_d;
  logic             fsync_q, fs_rise, idle, start_page;
  logic [AW-1:0]    base;
  logic [WPL_W-1:0] wpl;
  logic [LN_W-1:0]  lines;
  logic [TW-1:0]    total;
  logic             arm, pop, urun_set, page_done;
  logic [DW-1:0]    head;
  logic             empty, full, fetch_done;

  assign idle        = state_q == ST_IDLE;
  assign fs_rise     = fsync_i && !fsync_q;
  assign start_page  = state_q == ST_WAIT && fs_rise;
  assign print_req_o = state_q == ST_WAIT;
  assign total       = TW'(wpl) * TW'(cfg_wdata_i[LN_W-1:0]);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (arm)                state_d = ST_FILL;
      ST_FILL: if (full || fetch_done) state_d = ST_WAIT;
      ST_WAIT: if (fs_rise)            state_d = ST_RUN;
      ST_RUN:  if (page_done)          state_d = ST_IDLE;
      default:                         state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      fsync_q <= 1'b0;
    end else begin
      state_q <= state_d;
      fsync_q <= fsync_i;
    end
  end

  pvc_regs #(.AW(AW), .WPL_W(WPL_W), .LN_W(LN_W)) u_regs (
    .clk_i, .rst_ni,
    .cfg_we_i, .cfg_addr_i, .cfg_wdata_i,
    .idle_i     (idle),
    .set_band_i (start_page),
    .set_page_i (page_done),
    .set_urun_i (urun_set),
    .base_o     (base),
    .wpl_o      (wpl),
    .lines_o    (lines),
    .arm_o      (arm),
    .irq_band_o, .irq_page_o,
    .urun_o     (underrun_o)
  );

  pvc_fetch #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .TW(TW)) u_fetch (
    .clk_i, .rst_ni,
    .active_i (!idle),
    .start_i  (arm),
    .base_i   (base),
    .total_i  (total),
    .pop_i    (pop),
    .mem_req_o, .mem_addr_o, .mem_ack_i, .mem_rdata_i,
    .head_o   (head),
    .empty_o  (empty),
    .full_o   (full),
    .done_o   (fetch_done)
  );

  pvc_shift #(.DW(DW), .WPL_W(WPL_W), .LN_W(LN_W)) u_shift (
    .clk_i, .rst_ni,
    .run_i       (state_q == ST_RUN),
    .start_i     (start_page),
    .wpl_i       (wpl),
    .lines_i     (lines),
    .vclk_i, .lsync_i,
    .head_i      (head),
    .empty_i     (empty),
    .pop_o       (pop),
    .urun_o      (urun_set),
    .page_done_o (page_done),
    .video_o
  );

  // R2
  arm_fetch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm |=> (mem_req_o && mem_addr_o == $past(base)));
  // R4
  band_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_band_o) |-> !print_req_o);
endmodule

// File: tb/page_video_ctrl_bench.sv
module page_video_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 20;
  localparam int WATCHDOG = 150000;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cfg_we_i = 1'b0;
  logic [1:0]    cfg_addr_i = '0;
  logic [AW-1:0] cfg_wdata_i = '0;
  logic          mem_req_o;
  logic [AW-1:0] mem_addr_o;
  logic          mem_ack_i = 1'b0;
  logic [15:0]   mem_rdata_i = '0;
  logic          print_req_o;
  logic          fsync_i = 1'b0, lsync_i = 1'b0, vclk_i = 1'b0;
  logic          video_o, irq_band_o, irq_page_o, underrun_o;

  int errors = 0, checks = 0, cyc = 0;
  int vhalf = 2, vcnt = 0, lsync_per = 160, lcnt = 0, ack_div = 1, ack_wait = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  page_video_ctrl u_page_video_ctrl (
    .clk_i(clk), .rst_ni, .cfg_we_i, .cfg_addr_i, .cfg_wdata_i,
    .mem_req_o, .mem_addr_o, .mem_ack_i, .mem_rdata_i,
    .print_req_o, .fsync_i, .lsync_i, .vclk_i, .video_o,
    .irq_band_o, .irq_page_o, .underrun_o
  );

  function automatic int pat(int a);
    return ((a * 40503 + 12345) ^ (a >> 3)) & 16'hFFFF;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // reference model: 0 idle, 1 fill, 2 wait, 3 run
  int m_st = 0, m_base = 0, m_wpl = 0, m_lines = 0;
  int m_fleft = 0, m_faddr = 0, m_sh = 0, m_bits = 0, m_wl = 0, m_ll = 0;
  bit m_vq, m_lq, m_fq, m_pend, m_inl, m_video, m_band, m_page, m_urun, m_expreq;
  int q[$];

  always @(posedge clk) begin
    if (!rst_ni) begin
      m_st = 0; m_base = 0; m_wpl = 0; m_lines = 0; m_fleft = 0; m_faddr = 0;
      m_vq = 0; m_lq = 0; m_fq = 0; m_pend = 0; m_inl = 0; m_video = 0;
      m_band = 0; m_page = 0; m_urun = 0; m_expreq = 0; q.delete();
    end else begin
      automatic bit vr = vclk_i && !m_vq;
      automatic bit lr = lsync_i && !m_lq;
      automatic bit fr = fsync_i && !m_fq;
      automatic int st = m_st;
      automatic int qsz0 = q.size();
      automatic int fl0 = m_fleft;
      automatic bit ack = mem_ack_i && m_expreq;
      automatic bit arm = 0, sband = 0, spage = 0, surun = 0;
      automatic int clr = 0;
      automatic int wpl0 = m_wpl, base0 = m_base;
      if (cfg_we_i) begin
        if (cfg_addr_i == 3) clr = cfg_wdata_i[2:0];
        else if (st == 0) begin
          if (cfg_addr_i == 0) m_base = cfg_wdata_i;
          if (cfg_addr_i == 1) m_wpl = cfg_wdata_i[9:0];
          if (cfg_addr_i == 2) begin
            m_lines = cfg_wdata_i[13:0];
            if (m_lines != 0 && wpl0 != 0) arm = 1;
          end
        end
      end
      if (st == 3) begin
        automatic bit inl0 = m_inl;
        automatic bit load = vr && ((!m_inl && m_pend) || (m_inl && m_bits == 0 && m_wl != 0));
        automatic bit endl = vr && m_inl && m_bits == 0 && m_wl == 0;
        if (lr && !inl0) m_pend = 1;
        if (load) begin
          automatic int w = 0;
          if (q.size() == 0) surun = 1; else w = q.pop_front();
          m_video = w[15]; m_sh = (w << 1) & 16'hFFFF; m_bits = 15;
          m_wl = inl0 ? m_wl - 1 : m_wpl - 1;
          m_inl = 1; m_pend = 0;
        end else if (vr && m_inl && m_bits != 0) begin
          m_video = m_sh[15]; m_sh = (m_sh << 1) & 16'hFFFF; m_bits--;
        end else if (endl) begin
          m_video = 0; m_inl = 0;
          if (m_ll == 1) spage = 1;
          m_ll--;
        end
      end
      if (st == 2 && fr) begin
        m_ll = m_lines; m_pend = 0; m_inl = 0; m_video = 0; sband = 1;
      end
      if (arm) begin
        q.delete(); m_fleft = wpl0 * m_lines; m_faddr = base0;
      end else if (ack) begin
        q.push_back(pat(m_faddr)); m_faddr++; m_fleft--;
      end
      case (st)
        0: if (arm) m_st = 1;
        1: if (qsz0 == 2 || fl0 == 0) m_st = 2;
        2: if (fr) m_st = 3;
        3: if (spage) m_st = 0;
        default: ;
      endcase
      m_band = (m_band && !clr[0]) || sband;
      m_page = (m_page && !clr[1]) || spage;
      m_urun = (m_urun && !clr[2]) || surun;
      m_vq = vclk_i; m_lq = lsync_i; m_fq = fsync_i;
      m_expreq = m_st != 0 && m_fleft > 0 && q.size() < 2;
    end
  end

  // per-cycle compare, then memory responder
  always @(negedge clk) begin
    if (rst_ni) begin
      check("video R5 R6 R7", video_o, m_video);
      check("print_req R4", print_req_o, m_st == 2);
      check("irq_band R4", irq_band_o, m_band);
      check("irq_page R8", irq_page_o, m_page);
      check("underrun R9", underrun_o, m_urun);
      check("mem_req R3", mem_req_o, m_expreq);
      if (m_expreq) check("mem_addr R3", mem_addr_o, m_faddr & ((1 << AW) - 1));
    end
    if (mem_req_o) begin
      if (ack_wait >= ack_div - 1) begin mem_ack_i <= 1'b1; ack_wait = 0; end
      else begin mem_ack_i <= 1'b0; ack_wait++; end
    end else mem_ack_i <= 1'b0;
    mem_rdata_i <= 16'(pat(int'(mem_addr_o)));
  end

  // engine stimulus
  always @(negedge clk) begin
    vcnt = (vcnt + 1) % (2 * vhalf);
    vclk_i <= vcnt < vhalf;
    lcnt = (lcnt + 1) % lsync_per;
    lsync_i <= lcnt < 3;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk);
    cfg_we_i = 1'b1; cfg_addr_i = 2'(a); cfg_wdata_i = AW'(d);
    @(negedge clk);
    cfg_we_i = 1'b0;
  endtask

  task automatic run_page(int base, int wpl, int lines);
    wr(0, base);
    wr(1, wpl);
    wr(2, lines);
    check("R2 req after arm", mem_req_o, 1);
    check("R2 first address", mem_addr_o, base);
    while (!print_req_o) @(negedge clk);
    repeat (3) @(negedge clk);
    fsync_i = 1'b1;
    repeat (3) @(negedge clk);
    fsync_i = 1'b0;
    while (!irq_page_o) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check("R1 mem_req", mem_req_o, 0);
    check("R1 print_req", print_req_o, 0);
    check("R1 video", video_o, 0);
    check("R1 irqs", {irq_band_o, irq_page_o, underrun_o}, 0);
    rst_ni = 1'b1;

    // normal page, fast memory
    run_page('h100, 2, 3);
    check("R8 page end", irq_page_o, 1);
    check("R4 band flag", irq_band_o, 1);
    check("R9 no underrun", underrun_o, 0);
    wr(3, 0);
    check("R10 zero write keeps page", irq_page_o, 1);
    check("R10 zero write keeps band", irq_band_o, 1);
    wr(3, 2);
    check("R10 page cleared", irq_page_o, 0);
    check("R10 band kept", irq_band_o, 1);
    wr(3, 7);
    check("R10 all cleared", irq_band_o, 0);

    // zero line count must not arm
    wr(2, 0);
    repeat (10) @(negedge clk);
    check("R2 zero count no fetch", mem_req_o, 0);
    check("R2 zero count no print req", print_req_o, 0);

    // slow memory, fast video clock: underrun
    vhalf = 1; lsync_per = 40; ack_div = 60;
    run_page('hFFFFE, 1, 4);
    check("R9 underrun set", underrun_o, 1);
    wr(3, 4);
    check("R10 underrun cleared", underrun_o, 0);
    wr(3, 3);

    // line sync faster than a line: extra edges ignored
    vhalf = 2; lsync_per = 50; ack_div = 1;
    run_page('h2345, 2, 2);
    check("R7 page completes", irq_page_o, 1);
    check("R9 still no underrun", underrun_o, 0);

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule